// File: doc/BRIEF.md
# Timer Capture/Compare Channel

This block is one channel that sits beside a free-running timer counter shared with other channels. The counter value, the update event and the counting itself arrive from outside. A 2-bit direction field selects what the channel does. As an output, it compares the counter with its register and drives a reference waveform, which can be set, cleared, toggled, forced or pulse-width modulated. That waveform then passes through polarity and enable logic to the pin. As an input, it watches its own pin or the neighbouring channel's pin for a chosen edge. It can divide those events by 1, 2, 4 or 8, and it latches the counter into the same register on each accepted event.

A single register holds the compare value in output mode and the captured value in input mode. In output mode, software writes reach it either at once or through a shadow copy that loads at the update event. In input mode the register cannot be written by software. One event flag serves both directions. A second flag records a capture that arrives while the event flag is still set.

Top module: `tmr_ccchan`

## Requirements
- R1: While reset is held, `ccr_val`, `evt_flag`, `ovr_flag`, `oc_ref` and `ch_pin` are all 0.
- R2: `dir_sel` 00 makes the channel an output. 01 takes capture events from `pin_self`. 10 takes them from `pin_nbr`. 11 accepts no capture events. In every input setting `oc_ref` is held at 0.
- R3: With `dir_sel` = 00 and `pre_en` = 0, a write (`sw_wr`) appears on `ccr_val` after the next clock edge. With `dir_sel` nonzero, writes leave `ccr_val` unchanged.
- R4: With `dir_sel` = 00 and `pre_en` = 1, a write goes only to a shadow copy. `ccr_val` takes the shadow value at the next `upd_evt` pulse.
- R5: A match occurs in the first cycle in which `cnt_in` equals `ccr_val`. On a match, `oc_mode` 0001 sets `oc_ref` to 1, 0010 clears it to 0, 0011 inverts it, and 0000 leaves it unchanged. `upd_evt` has no effect on `oc_ref` in these modes. `oc_ref` is registered and changes one clock after the condition that moves it.
- R6: `oc_mode` 0100 drives `oc_ref` to 0 and 0101 drives it to 1, whatever the counter does. A match still sets `evt_flag` in these modes.
- R7: `oc_mode` 0110 gives `oc_ref` = 1 when `cnt_in` < `ccr_val` and 0 otherwise. `oc_mode` 0111 gives `oc_ref` = 1 when `cnt_in` >= `ccr_val` and 0 otherwise. Each is registered with one clock of delay.
- R8: `ch_pin` = `oc_ref` XOR `pol_inv` when `dir_sel` = 00 and `ch_en` = 1, and 0 otherwise. `pol_inv` = 0 means active high and 1 means active low.
- R9: `edge_sel` 00 accepts rising edges, 01 falling edges, 11 both edges. 10 accepts none.
- R10: An accepted capture loads `cnt_in` into `ccr_val` and sets `evt_flag`. If `evt_flag` was already set, the capture also sets `ovr_flag`.
- R11: `evt_flag` clears on `sw_clr_flag`, or on `sw_rd` while `dir_sel` is nonzero. `ovr_flag` clears only on `sw_clr_ovr`. A new event in the same cycle takes priority over a clear.
- R12: `div_sel` 00, 01, 10 and 11 capture on every 1st, 2nd, 4th and 8th accepted edge respectively. The edge count restarts whenever the channel is an output or `ch_en` is 0.
- R13: In input mode, captures happen only while `ch_en` = 1. A pin level present before clock edge k is captured at edge k+2, using the `cnt_in` value that stands before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cnt_in | input | W | Shared counter value |
| upd_evt | input | 1 | Update event pulse from the counter |
| dir_sel | input | 2 | Channel direction and input source |
| oc_mode | input | 4 | Output reference mode |
| pre_en | input | 1 | Compare shadow enable |
| pol_inv | input | 1 | Output polarity (1 = active low) |
| ch_en | input | 1 | Pin enable (output) or capture enable (input) |
| edge_sel | input | 2 | Capture edge selection |
| div_sel | input | 2 | Capture event divider |
| pin_self | input | 1 | This channel's input pin |
| pin_nbr | input | 1 | Neighbouring channel's input pin |
| sw_wr | input | 1 | Software write strobe for the register |
| sw_wdata | input | W | Software write data |
| sw_rd | input | 1 | Software read strobe for the register |
| sw_clr_flag | input | 1 | Clear the event flag |
| sw_clr_ovr | input | 1 | Clear the over-capture flag |
| ccr_val | output | W | Capture/compare register value |
| evt_flag | output | 1 | Match or capture flag |
| ovr_flag | output | 1 | Over-capture flag |
| oc_ref | output | 1 | Output reference waveform |
| ch_pin | output | 1 | Output pin after polarity and enable |

## Verification
The assertions assume reset is asserted from time zero. They also assume the strobes and the configuration fields are held steady from one clock edge to the next, which the stimulus guarantees by changing every input only at falling clock edges. The pins are treated as asynchronous and pass through a synchroniser, but the stimulus holds each pin level for at least three clocks, so that no edge can merge with the next. The counter input is driven directly by the stimulus, so each latched value is known beforehand. In capture tests it is held steady across the synchroniser delay.

// File: rtl/tmr_ccchan.sv
module tmr_ccchan #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cnt_in,
  input  logic         upd_evt,
  input  logic [1:0]   dir_sel,
  input  logic [3:0]   oc_mode,
  input  logic         pre_en,
  input  logic         pol_inv,
  input  logic         ch_en,
  input  logic [1:0]   edge_sel,
  input  logic [1:0]   div_sel,
  input  logic         pin_self,
  input  logic         pin_nbr,
  input  logic         sw_wr,
  input  logic [W-1:0] sw_wdata,
  input  logic         sw_rd,
  input  logic         sw_clr_flag,
  input  logic         sw_clr_ovr,
  output logic [W-1:0] ccr_val,
  output logic         evt_flag,
  output logic         ovr_flag,
  output logic         oc_ref,
  output logic         ch_pin
);

  logic [2:0]   sy_self, sy_nbr;
  logic [2:0]   div_cnt, div_lim;
  logic [W-1:0] ccr_act, ccr_pre;
  logic         in_mode, sel_evt, evt_ok, cap_fire;
  logic         eq_now, eq_d, hit, set_flag, clr_flag;

  function automatic logic edge_ok(input logic r, input logic f, input logic [1:0] s);
    case (s)
      2'b00:   return r;
      2'b01:   return f;
      2'b11:   return r | f;
      default: return 1'b0;
    endcase
  endfunction

  assign in_mode = (dir_sel != 2'b00);

  // input synchronisers, one per pin
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sy_self <= '0;
      sy_nbr  <= '0;
    end else begin
      sy_self <= {sy_self[1:0], pin_self};
      sy_nbr  <= {sy_nbr[1:0], pin_nbr};
    end
  end

  always_comb begin
    case (dir_sel)
      2'b01:   sel_evt = edge_ok(sy_self[1] & ~sy_self[2], ~sy_self[1] & sy_self[2], edge_sel);
      2'b10:   sel_evt = edge_ok(sy_nbr[1] & ~sy_nbr[2], ~sy_nbr[1] & sy_nbr[2], edge_sel);
      default: sel_evt = 1'b0;
    endcase
  end

  assign evt_ok = sel_evt & ch_en;

  always_comb begin
    case (div_sel)
      2'b00:   div_lim = 3'd0;
      2'b01:   div_lim = 3'd1;
      2'b10:   div_lim = 3'd3;
      default: div_lim = 3'd7;
    endcase
  end

  assign cap_fire = evt_ok && (div_cnt == div_lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                div_cnt <= '0;
    else if (!in_mode || !ch_en) div_cnt <= '0;
    else if (evt_ok)           div_cnt <= cap_fire ? 3'd0 : div_cnt + 3'd1;
  end

  // shared capture/compare register with shadow copy
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ccr_act <= '0;
      ccr_pre <= '0;
    end else begin
      if (!in_mode && sw_wr) ccr_pre <= sw_wdata;
      if (cap_fire)
        ccr_act <= cnt_in;
      else if (!in_mode) begin
        if (sw_wr && !pre_en)        ccr_act <= sw_wdata;
        else if (upd_evt && pre_en)  ccr_act <= ccr_pre;
      end
    end
  end

  assign ccr_val = ccr_act;

  // compare path
  assign eq_now = (cnt_in == ccr_act);
  assign hit    = !in_mode && eq_now && !eq_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) eq_d <= 1'b0;
    else        eq_d <= eq_now && !in_mode;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      oc_ref <= 1'b0;
    else if (in_mode)
      oc_ref <= 1'b0;
    else begin
      case (oc_mode)
        4'b0001: if (hit) oc_ref <= 1'b1;
        4'b0010: if (hit) oc_ref <= 1'b0;
        4'b0011: if (hit) oc_ref <= ~oc_ref;
        4'b0100: oc_ref <= 1'b0;
        4'b0101: oc_ref <= 1'b1;
        4'b0110: oc_ref <= (cnt_in < ccr_act);
        4'b0111: oc_ref <= (cnt_in >= ccr_act);
        default: oc_ref <= oc_ref;
      endcase
    end
  end

  assign ch_pin = !in_mode && ch_en && (oc_ref ^ pol_inv);

  // flags
  assign set_flag = cap_fire | hit;
  assign clr_flag = sw_clr_flag | (sw_rd & in_mode);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_flag <= 1'b0;
      ovr_flag <= 1'b0;
    end else begin
      if (set_flag)      evt_flag <= 1'b1;
      else if (clr_flag) evt_flag <= 1'b0;
      if (cap_fire && evt_flag) ovr_flag <= 1'b1;
      else if (sw_clr_ovr)      ovr_flag <= 1'b0;
    end
  end

  AST_RO_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_mode && !cap_fire) |=> $stable(ccr_val)); // R3
  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_clr_flag && !set_flag) |=> !evt_flag); // R11
  AST_OVR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_flag) |-> ($past(evt_flag) && $past(cap_fire))); // R10
  AST_FORCE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_mode && oc_mode == 4'b0101) |=> oc_ref); // R6
  AST_FORCE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_mode && oc_mode == 4'b0100) |=> !oc_ref); // R6
  AST_INPUT_REF: assert property (@(posedge clk) disable iff (!rst_n)
    in_mode |=> !oc_ref); // R2

endmodule

// File: tb/tmr_ccchan_bench.sv
module tmr_ccchan_bench;
  localparam int CLK_PER = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cnt_in = '0;
  logic        upd_evt = 1'b0;
  logic [1:0]  dir_sel = '0;
  logic [3:0]  oc_mode = '0;
  logic        pre_en = 1'b0, pol_inv = 1'b0, ch_en = 1'b0;
  logic [1:0]  edge_sel = '0, div_sel = '0;
  logic        pin_self = 1'b0, pin_nbr = 1'b0;
  logic        sw_wr = 1'b0, sw_rd = 1'b0, sw_clr_flag = 1'b0, sw_clr_ovr = 1'b0;
  logic [15:0] sw_wdata = '0;
  logic [15:0] ccr_val;
  logic        evt_flag, ovr_flag, oc_ref, ch_pin;

  int n_chk = 0, n_bad = 0;

  tmr_ccchan #(.W(16)) u_tmr_ccchan (
    .clk(clk), .rst_n(rst_n), .cnt_in(cnt_in), .upd_evt(upd_evt),
    .dir_sel(dir_sel), .oc_mode(oc_mode), .pre_en(pre_en), .pol_inv(pol_inv),
    .ch_en(ch_en), .edge_sel(edge_sel), .div_sel(div_sel),
    .pin_self(pin_self), .pin_nbr(pin_nbr), .sw_wr(sw_wr), .sw_wdata(sw_wdata),
    .sw_rd(sw_rd), .sw_clr_flag(sw_clr_flag), .sw_clr_ovr(sw_clr_ovr),
    .ccr_val(ccr_val), .evt_flag(evt_flag), .ovr_flag(ovr_flag),
    .oc_ref(oc_ref), .ch_pin(ch_pin)
  );

  always #(CLK_PER/2) clk = ~clk;

  function automatic logic pwm_exp(input logic [3:0] m, input logic [15:0] c, input logic [15:0] cmp);
    return (m == 4'b0110) ? (c < cmp) : (c >= cmp);
  endfunction

  function automatic logic pin_exp(input logic r, input logic p, input logic en, input logic [1:0] d);
    return (d == 2'b00) && en && (r ^ p);
  endfunction

  function automatic logic cap_exp(input logic [1:0] es, input logic oldv, input logic newv);
    case (es)
      2'b00:   return !oldv && newv;
      2'b01:   return oldv && !newv;
      2'b11:   return oldv != newv;
      default: return 1'b0;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_wr(input logic [15:0] v);
    sw_wdata = v; sw_wr = 1'b1; cyc(1); sw_wr = 1'b0;
  endtask

  task automatic do_upd();
    upd_evt = 1'b1; cyc(1); upd_evt = 1'b0;
  endtask

  task automatic do_rd();
    sw_rd = 1'b1; cyc(1); sw_rd = 1'b0;
  endtask

  task automatic do_clrf();
    sw_clr_flag = 1'b1; cyc(1); sw_clr_flag = 1'b0;
  endtask

  task automatic do_clro();
    sw_clr_ovr = 1'b1; cyc(1); sw_clr_ovr = 1'b0;
  endtask

  task automatic set_cnt(input logic [15:0] v);
    cnt_in = v; cyc(1);
  endtask

  task automatic pin_to(input logic a, input logic b);
    pin_self = a; pin_nbr = b; cyc(3);
  endtask

  initial begin
    #(CLK_PER * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog got=hung exp=done");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] exp_ccr;
    logic        lvl;
    void'($urandom(32'd2024));
    cyc(2);
    chk("R1 ccr", ccr_val, 0);
    chk("R1 flag", evt_flag, 0);
    chk("R1 ovr", ovr_flag, 0);
    chk("R1 ref", oc_ref, 0);
    chk("R1 pin", ch_pin, 0);
    rst_n = 1'b1;
    cyc(1);

    ch_en = 1'b1;
    do_wr(16'd100);
    chk("R3 direct write", ccr_val, 100);
    pre_en = 1'b1;
    do_wr(16'd200);
    chk("R4 shadow hold", ccr_val, 100);
    do_upd();
    chk("R4 shadow load", ccr_val, 200);
    pre_en = 1'b0;
    dir_sel = 2'b01;
    do_wr(16'd55);
    chk("R3 read only", ccr_val, 200);
    dir_sel = 2'b00;
    do_wr(16'd50);
    do_clrf();
    chk("R11 flag clear", evt_flag, 0);

    oc_mode = 4'b0001; set_cnt(16'd50);
    chk("R5 set on match", oc_ref, 1);
    chk("R5 match flag", evt_flag, 1);
    chk("R8 pin high", ch_pin, 1);
    do_clrf();
    chk("R11 clear after match", evt_flag, 0);
    oc_mode = 4'b0010; set_cnt(16'd51); set_cnt(16'd50);
    chk("R5 clear on match", oc_ref, 0);
    oc_mode = 4'b0011; set_cnt(16'd51); set_cnt(16'd50);
    chk("R5 toggle 1", oc_ref, 1);
    set_cnt(16'd51); set_cnt(16'd50);
    chk("R5 toggle 2", oc_ref, 0);
    set_cnt(16'd51); set_cnt(16'd50);
    chk("R5 toggle 3", oc_ref, 1);
    do_upd();
    chk("R5 update no effect", oc_ref, 1);
    oc_mode = 4'b0000; set_cnt(16'd51); set_cnt(16'd50);
    chk("R5 frozen", oc_ref, 1);

    do_clrf();
    oc_mode = 4'b0100; set_cnt(16'd51);
    chk("R6 force low", oc_ref, 0);
    set_cnt(16'd50);
    chk("R6 force low on match", oc_ref, 0);
    chk("R6 flag in forced mode", evt_flag, 1);
    oc_mode = 4'b0101; cyc(1);
    chk("R6 force high", oc_ref, 1);
    pol_inv = 1'b1; cyc(1);
    chk("R8 active low", ch_pin, 0);
    ch_en = 1'b0; cyc(1);
    chk("R8 disabled", ch_pin, 0);
    pol_inv = 1'b0; cyc(1);
    chk("R8 disabled high", ch_pin, 0);
    ch_en = 1'b1; cyc(1);
    chk("R8 enabled", ch_pin, 1);

    oc_mode = 4'b0110; set_cnt(16'd50);
    chk("R7 pwm1 equal", oc_ref, 0);
    set_cnt(16'd49);
    chk("R7 pwm1 below", oc_ref, 1);
    oc_mode = 4'b0111; cyc(1);
    chk("R7 pwm2 below", oc_ref, 0);
    set_cnt(16'd50);
    chk("R7 pwm2 equal", oc_ref, 1);

    for (int i = 0; i < 40; i++) begin
      logic [15:0] c, cm;
      logic [3:0]  m;
      c  = 16'($urandom_range(0, 255));
      cm = 16'($urandom_range(0, 255));
      m  = ($urandom_range(0, 1) == 0) ? 4'b0110 : 4'b0111;
      do_wr(cm);
      oc_mode = m; cnt_in = c;
      pol_inv = 1'($urandom_range(0, 1));
      ch_en   = 1'($urandom_range(0, 1));
      cyc(1);
      chk("R7 random pwm", oc_ref, pwm_exp(m, c, cm));
      chk("R8 random pin", ch_pin, pin_exp(pwm_exp(m, c, cm), pol_inv, ch_en, dir_sel));
    end
    oc_mode = 4'b0000; ch_en = 1'b1; pol_inv = 1'b0;

    dir_sel = 2'b01; edge_sel = 2'b00; div_sel = 2'b00;
    cyc(1);
    do_clrf(); do_clro();
    chk("R2 input ref low", oc_ref, 0);
    cnt_in = 16'h1234; pin_to(1'b1, 1'b0);
    chk("R10 capture", ccr_val, 16'h1234);
    chk("R10 flag", evt_flag, 1);
    chk("R10 no overcapture", ovr_flag, 0);
    cnt_in = 16'h1999; pin_to(1'b0, 1'b0);
    chk("R9 rising ignores fall", ccr_val, 16'h1234);
    cnt_in = 16'h2222; pin_to(1'b1, 1'b0);
    chk("R10 second capture", ccr_val, 16'h2222);
    chk("R10 overcapture", ovr_flag, 1);
    do_rd();
    chk("R11 read clears flag", evt_flag, 0);
    chk("R11 read keeps ovr", ovr_flag, 1);
    do_clro();
    chk("R11 ovr clear", ovr_flag, 0);

    edge_sel = 2'b01;
    cnt_in = 16'h3333; pin_to(1'b0, 1'b0);
    chk("R9 falling", ccr_val, 16'h3333);
    cnt_in = 16'h4444; pin_to(1'b1, 1'b0);
    chk("R9 falling ignores rise", ccr_val, 16'h3333);
    edge_sel = 2'b11;
    cnt_in = 16'h5555; pin_to(1'b0, 1'b0);
    chk("R9 both fall", ccr_val, 16'h5555);
    cnt_in = 16'h6666; pin_to(1'b1, 1'b0);
    chk("R9 both rise", ccr_val, 16'h6666);
    edge_sel = 2'b10;
    cnt_in = 16'h7777; pin_to(1'b0, 1'b0);
    chk("R9 reserved", ccr_val, 16'h6666);

    edge_sel = 2'b00; dir_sel = 2'b10;
    cnt_in = 16'h1111; pin_to(1'b1, 1'b0);
    chk("R2 neighbour ignores own pin", ccr_val, 16'h6666);
    pin_to(1'b1, 1'b1);
    chk("R2 neighbour pin", ccr_val, 16'h1111);
    pin_to(1'b0, 1'b0);
    dir_sel = 2'b11;
    cnt_in = 16'h0abc; pin_to(1'b1, 1'b1);
    chk("R2 no source", ccr_val, 16'h1111);
    pin_to(1'b0, 1'b0);

    dir_sel = 2'b01; ch_en = 1'b0;
    cnt_in = 16'h0bad; pin_to(1'b1, 1'b0);
    chk("R13 capture disabled", ccr_val, 16'h1111);
    pin_to(1'b0, 1'b0);
    ch_en = 1'b1;
    cnt_in = 16'h0c0d; pin_self = 1'b1; cyc(2);
    chk("R13 not yet captured", ccr_val, 16'h1111);
    cyc(1);
    chk("R13 captured at third edge", ccr_val, 16'h0c0d);
    pin_to(1'b0, 1'b0);

    exp_ccr = 16'h0c0d;
    for (int d = 1; d < 4; d++) begin
      int n;
      n = 1 << d;
      div_sel = 2'(d);
      ch_en = 1'b0; cyc(1); ch_en = 1'b1;
      for (int e = 1; e <= 2 * n; e++) begin
        cnt_in = 16'(e * 16 + d);
        pin_to(1'b1, 1'b0);
        if (e % n == 0) exp_ccr = cnt_in;
        chk("R12 divider", ccr_val, exp_ccr);
        pin_to(1'b0, 1'b0);
      end
    end

    div_sel = 2'b00; lvl = 1'b0;
    for (int i = 0; i < 30; i++) begin
      logic [1:0] es;
      case ($urandom_range(0, 2))
        0:       es = 2'b00;
        1:       es = 2'b01;
        default: es = 2'b11;
      endcase
      edge_sel = es;
      cnt_in = 16'($urandom);
      if (cap_exp(es, lvl, ~lvl)) exp_ccr = cnt_in;
      lvl = ~lvl;
      pin_to(lvl, 1'b0);
      chk("R10 random capture", ccr_val, exp_ccr);
    end

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule